// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of a free-running 16-bit timer count whenever a qualifying transition shows up on a trigger line. Two asynchronous trigger lines are wired in: a primary one and an alternate one. A single control bit chooses which of the two is watched. Each line is brought into the clock domain by a two-flop synchronizer. Each line also has a run-length noise filter, which can be switched in or out. Both lines use identical logic. The chosen level then feeds an edge detector, and a polarity bit selects whether a rise or a fall counts as an event.

There is no dedicated capture storage. The snapshot lands in the two byte-wide compare registers that the timer's compare logic also uses:
- In narrow mode only the low byte is captured, into the low compare register. The high register keeps serving compare.
- In wide mode both bytes are captured and the compare function is switched off.

Every capture raises a sticky flag in the same cycle as the data update. When interrupts are enabled, the flag drives an interrupt request. The flag is cleared in one of two ways: by an acknowledge pulse, or by software writing a one to bit 0 of the flag location.

Software reaches the block through a small register port with one shared address:
- address 0 is the low compare register;
- address 1 is the high compare register;
- address 2 is the flag, in bit 0;
- address 3 reads as zero.

Top module: `capture_unit`

## Requirements
- R1: After a synchronous reset, both compare registers, the flag and the interrupt output are 0.
- R2: With the filter off, a qualifying transition on the selected trigger line updates the low compare register with the low byte of the count at the third rising clock edge after the change. That is two synchronizer stages plus one edge stage.
- R3: In narrow mode (wide_mode_i=0), a capture leaves the high compare register unchanged, software writes to address 1 still reach it, and cmp_en_o is 1.
- R4: In wide mode (wide_mode_i=1), a capture also loads the high byte of the count into the high compare register, and cmp_en_o is 0.
- R5: The flag rises in the same cycle that the captured value appears, and it never rises without a capture.
- R6: irq_o is 1 exactly when the flag is set and irq_en_i is 1.
- R7: The flag clears on irq_ack_i, or on a write to address 2 with bit 0 set. A write with bit 0 clear leaves the flag unchanged.
- R8: When a capture and a flag clear occur in the same cycle, the flag stays set.
- R9: With edge_rise_i=1 only rising transitions capture. With edge_rise_i=0 only falling transitions capture.
- R10: src_alt_i=0 watches trig_main_i and src_alt_i=1 watches trig_alt_i. Activity on the other line causes no capture.
- R11: Changing src_alt_i while the two synchronized levels differ can produce a capture one cycle later. That flag can be cleared at once.
- R12: With filt_en_i=1, a new level is accepted only after four consecutive equal samples. Captures come four cycles later than with the filter off, and pulses of three cycles or less are rejected.
- R13: The register read port is combinational: address 0 gives the low compare register, 1 the high one, 2 the flag in bit 0, and 3 reads 0.
- R14: A capture overrides a software write to the same compare register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | 16 | Free-running timer count |
| trig_main_i | input | 1 | Primary asynchronous trigger line |
| trig_alt_i | input | 1 | Alternate asynchronous trigger line |
| src_alt_i | input | 1 | 1 selects the alternate trigger line |
| edge_rise_i | input | 1 | 1 = capture on rising, 0 = on falling |
| filt_en_i | input | 1 | Insert the noise filter |
| wide_mode_i | input | 1 | 1 = 16-bit capture into both registers |
| irq_en_i | input | 1 | Interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| cmp_lo_o | output | 8 | Low compare / capture register |
| cmp_hi_o | output | 8 | High compare / capture register |
| cmp_en_o | output | 1 | Compare function allowed (narrow mode) |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of actions can collide in one clock: a capture with a flag clear, and a capture with a software write to the low compare register. The bench provokes each collision by counting edges from the trigger change and asserting the write strobe exactly on the third rising edge. It then judges the outcome: the flag must remain set and the low register must hold the count byte rather than the written data. A cycle-accurate behavioural model runs alongside, so every intermediate cycle of these collisions is also compared.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 2;
    localparam int N_SRC  = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  count_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CMP_LO = 2'd0,
        REG_CMP_HI = 2'd1,
        REG_FLAG   = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    // Capture event: qualifying edge plus the count it stamps
    typedef struct packed {
        logic   hit;
        count_t stamp;
    } cap_evt_t;

    // Decoded software access
    typedef struct packed {
        logic  we_lo;
        logic  we_hi;
        logic  clr;
        byte_t data;
    } sw_wr_t;

    function automatic logic edge_match(input logic cur, input logic prev, input logic rise);
        return rise ? (cur & ~prev) : (~cur & prev);
    endfunction

    function automatic sw_wr_t decode_write(input logic en, input logic [ADDR_W-1:0] addr,
                                            input byte_t data);
        sw_wr_t w;
        w.we_lo = en && (reg_addr_e'(addr) == REG_CMP_LO);
        w.we_hi = en && (reg_addr_e'(addr) == REG_CMP_HI);
        w.clr   = en && (reg_addr_e'(addr) == REG_FLAG) && data[0];
        w.data  = data;
        return w;
    endfunction

endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
module icu_filter #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_i,
    output logic level_o
);
    localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic          level_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (sample_i == level_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            level_q <= sample_i;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/icu_front.sv
module icu_front
    import icu_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] trig_i,
    input  logic             src_alt_i,
    input  logic             filt_en_i,
    output logic             level_o
);
    logic [N_SRC-1:0] synced;
    logic [N_SRC-1:0] filtered;
    logic [N_SRC-1:0] chosen;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (trig_i[i]),
            .sync_o  (synced[i])
        );
        icu_filter #(.RUN_LEN(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .sample_i (synced[i]),
            .level_o  (filtered[i])
        );
        assign chosen[i] = filt_en_i ? filtered[i] : synced[i];
    end

    assign level_o = src_alt_i ? chosen[1] : chosen[0];
endmodule

// File: rtl/icu_edge.sv
module icu_edge
    import icu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     level_i,
    input  logic     edge_rise_i,
    input  count_t   count_i,
    output cap_evt_t evt_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    always_comb begin
        evt_o.hit   = edge_match(level_i, prev_q, edge_rise_i);
        evt_o.stamp = count_i;
    end
endmodule

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cap_evt_t          evt_i,
    input  logic              wide_i,
    input  sw_wr_t            sw_i,
    input  logic              ack_i,
    input  logic              irq_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output byte_t             lo_o,
    output byte_t             hi_o,
    output logic              flag_o,
    output logic              irq_o,
    output byte_t             rd_o
);
    byte_t lo_q, hi_q;
    logic  flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (evt_i.hit) begin
            lo_q <= evt_i.stamp[BYTE_W-1:0];
        end else if (sw_i.we_lo) begin
            lo_q <= sw_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (evt_i.hit && wide_i) begin
            hi_q <= evt_i.stamp[CNT_W-1:BYTE_W];
        end else if (sw_i.we_hi) begin
            hi_q <= sw_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (evt_i.hit) begin
            flag_q <= 1'b1;
        end else if (sw_i.clr || ack_i) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr_e'(addr_i))
            REG_CMP_LO: rd_o = lo_q;
            REG_CMP_HI: rd_o = hi_q;
            REG_FLAG:   rd_o = {{(BYTE_W-1){1'b0}}, flag_q};
            default:    rd_o = '0;
        endcase
    end

    assign lo_o   = lo_q;
    assign hi_o   = hi_q;
    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/capture_unit.sv
module capture_unit
    import icu_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              trig_main_i,
    input  logic              trig_alt_i,
    input  logic              src_alt_i,
    input  logic              edge_rise_i,
    input  logic              filt_en_i,
    input  logic              wide_mode_i,
    input  logic              irq_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic              irq_ack_i,
    output logic [BYTE_W-1:0] cmp_lo_o,
    output logic [BYTE_W-1:0] cmp_hi_o,
    output logic              cmp_en_o,
    output logic              flag_o,
    output logic              irq_o
);
    logic     sel_level;
    cap_evt_t evt;
    sw_wr_t   sw;
    logic     cap_hit;

    icu_front #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_front (
        .clk       (clk),
        .rst       (rst),
        .trig_i    ({trig_alt_i, trig_main_i}),
        .src_alt_i (src_alt_i),
        .filt_en_i (filt_en_i),
        .level_o   (sel_level)
    );

    icu_edge u_edge (
        .clk         (clk),
        .rst         (rst),
        .level_i     (sel_level),
        .edge_rise_i (edge_rise_i),
        .count_i     (count_i),
        .evt_o       (evt)
    );

    assign cap_hit = evt.hit;
    assign sw      = decode_write(wr_en_i, addr_i, wr_data_i);

    icu_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .wide_i   (wide_mode_i),
        .sw_i     (sw),
        .ack_i    (irq_ack_i),
        .irq_en_i (irq_en_i),
        .addr_i   (addr_i),
        .lo_o     (cmp_lo_o),
        .hi_o     (cmp_hi_o),
        .flag_o   (flag_o),
        .irq_o    (irq_o),
        .rd_o     (rd_data_o)
    );

    assign cmp_en_o = ~wide_mode_i;
endmodule

// File: rtl/icu_checker.sv
module icu_checker
    import icu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cap_hit,
    input logic [CNT_W-1:0]  count_i,
    input logic              wide_mode_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              clr_bit,
    input logic              irq_ack_i,
    input logic [BYTE_W-1:0] cmp_lo_o,
    input logic [BYTE_W-1:0] cmp_hi_o,
    input logic              flag_o,
    input logic              irq_o
);
    p_low_byte_r2: assert property (@(posedge clk) disable iff (rst)
        cap_hit |=> cmp_lo_o == $past(count_i[BYTE_W-1:0]));

    p_high_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_hit && !wide_mode_i && !(wr_en_i && addr_i == 2'd1)) |=> $stable(cmp_hi_o));

    p_high_byte_r4: assert property (@(posedge clk) disable iff (rst)
        (cap_hit && wide_mode_i) |=> cmp_hi_o == $past(count_i[CNT_W-1:BYTE_W]));

    p_flag_on_capture_r5: assert property (@(posedge clk) disable iff (rst)
        cap_hit |=> flag_o);

    p_no_spurious_flag_r5: assert property (@(posedge clk) disable iff (rst)
        !cap_hit |=> !$rose(flag_o));

    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_o);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_i && !cap_hit) |=> !flag_o);

    p_capture_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_hit && wr_en_i && addr_i == 2'd2 && clr_bit) |=> flag_o);

    p_write_loses_r14: assert property (@(posedge clk) disable iff (rst)
        (cap_hit && wr_en_i && addr_i == 2'd0) |=> cmp_lo_o == $past(count_i[BYTE_W-1:0]));
endmodule

bind capture_unit icu_checker u_icu_checker (
    .clk         (clk),
    .rst         (rst),
    .cap_hit     (cap_hit),
    .count_i     (count_i),
    .wide_mode_i (wide_mode_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .clr_bit     (wr_data_i[0]),
    .irq_ack_i   (irq_ack_i),
    .cmp_lo_o    (cmp_lo_o),
    .cmp_hi_o    (cmp_hi_o),
    .flag_o      (flag_o),
    .irq_o       (irq_o)
);

// File: tb/test_capture_unit.sv
`timescale 1ns/1ps
module test_capture_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt = 16'd0;
    logic        trig_main = 0, trig_alt = 0, src_alt = 0, edge_rise = 1;
    logic        filt_en = 0, wide = 0, irq_en = 0, wr_en = 0, ack = 0;
    logic [1:0]  addr = 2'd3;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rd_data, cmp_lo, cmp_hi;
    logic        cmp_en, flag, irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    capture_unit i_capture_unit (
        .clk(clk), .rst(rst), .count_i(cnt),
        .trig_main_i(trig_main), .trig_alt_i(trig_alt),
        .src_alt_i(src_alt), .edge_rise_i(edge_rise), .filt_en_i(filt_en),
        .wide_mode_i(wide), .irq_en_i(irq_en),
        .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data),
        .irq_ack_i(ack), .cmp_lo_o(cmp_lo), .cmp_hi_o(cmp_hi), .cmp_en_o(cmp_en),
        .flag_o(flag), .irq_o(irq)
    );

    always @(negedge clk) begin
        if (rst) cnt <= 16'd0;
        else     cnt <= cnt + 16'd7;
    end

    // ---------------- behavioural reference model ----------------
    bit   mq_main[$] = '{0, 0};
    bit   mq_alt[$]  = '{0, 0};
    bit   m_filt[2];
    int   m_run[2];
    bit   m_prev, m_flag;
    logic [7:0] m_lo, m_hi;
    bit   s0, s1, lvl, hit;

    always @(posedge clk) begin
        if (rst) begin
            mq_main = '{0, 0};
            mq_alt  = '{0, 0};
            m_filt  = '{0, 0};
            m_run   = '{0, 0};
            m_prev  = 0;
            m_flag  = 0;
            m_lo    = 8'd0;
            m_hi    = 8'd0;
        end else begin
            s0 = mq_main[0];
            s1 = mq_alt[0];
            if (filt_en) lvl = src_alt ? m_filt[1] : m_filt[0];
            else         lvl = src_alt ? s1 : s0;
            hit = edge_rise ? (lvl && !m_prev) : (!lvl && m_prev);
            m_prev = lvl;
            for (int i = 0; i < 2; i++) begin
                bit s;
                s = (i == 0) ? s0 : s1;
                if (s == m_filt[i]) m_run[i] = 0;
                else if (m_run[i] == 3) begin m_filt[i] = s; m_run[i] = 0; end
                else m_run[i] = m_run[i] + 1;
            end
            void'(mq_main.pop_front());
            mq_main.push_back(trig_main);
            void'(mq_alt.pop_front());
            mq_alt.push_back(trig_alt);
            if (hit) m_lo = cnt[7:0];
            else if (wr_en && addr == 2'd0) m_lo = wdata;
            if (hit && wide) m_hi = cnt[15:8];
            else if (wr_en && addr == 2'd1) m_hi = wdata;
            if (hit) m_flag = 1;
            else if ((wr_en && addr == 2'd2 && wdata[0]) || ack) m_flag = 0;
        end
    end

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (!rst && !done) begin
            case (addr)
                2'd0: exp_rd = m_lo;
                2'd1: exp_rd = m_hi;
                2'd2: exp_rd = {7'd0, m_flag};
                default: exp_rd = 8'd0;
            endcase
            check("R2 model cmp_lo", {8'd0, cmp_lo}, {8'd0, m_lo});
            check("R4 model cmp_hi", {8'd0, cmp_hi}, {8'd0, m_hi});
            check("R5 model flag", {15'd0, flag}, {15'd0, m_flag});
            check("R6 model irq", {15'd0, irq}, {15'd0, m_flag & irq_en});
            check("R3 model cmp_en", {15'd0, cmp_en}, {15'd0, ~wide});
            check("R13 model rd_data", {8'd0, rd_data}, {8'd0, exp_rd});
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1;
        step(1);
        wr_en = 0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        step(3);
        rst = 0;
        step(1);
        check("R1 reset flag", {15'd0, flag}, 16'd0);
        check("R1 reset irq", {15'd0, irq}, 16'd0);
        check("R1 reset cmp_lo", {8'd0, cmp_lo}, 16'd0);
        check("R1 reset cmp_hi", {8'd0, cmp_hi}, 16'd0);

        // narrow capture on rising edge of main line
        wr(2'd1, 8'hA5);
        trig_main = 1; v = cnt;
        step(2);
        check("R5 no flag before third edge", {15'd0, flag}, 16'd0);
        step(1);
        check("R2 low byte captured", {8'd0, cmp_lo}, {8'd0, 8'(v + 16'd14)});
        check("R5 flag with capture", {15'd0, flag}, 16'd1);
        check("R3 high reg untouched", {8'd0, cmp_hi}, 16'h00A5);
        check("R3 compare enabled", {15'd0, cmp_en}, 16'd1);
        check("R6 irq masked", {15'd0, irq}, 16'd0);
        irq_en = 1; #1;
        check("R6 irq raised", {15'd0, irq}, 16'd1);

        // clear by write
        wr(2'd2, 8'h00);
        check("R7 write zero keeps flag", {15'd0, flag}, 16'd1);
        wr(2'd2, 8'h01);
        check("R7 write one clears", {15'd0, flag}, 16'd0);
        check("R6 irq drops", {15'd0, irq}, 16'd0);

        // polarity
        trig_main = 0; step(5);
        check("R9 fall ignored in rise mode", {15'd0, flag}, 16'd0);
        edge_rise = 0;
        trig_main = 1; step(5);
        check("R9 rise ignored in fall mode", {15'd0, flag}, 16'd0);
        trig_main = 0; step(5);
        check("R9 fall captured", {15'd0, flag}, 16'd1);
        ack = 1; step(1); ack = 0;
        check("R7 ack clears", {15'd0, flag}, 16'd0);

        // source select
        edge_rise = 1;
        trig_alt = 1; step(5);
        check("R10 unselected line ignored", {15'd0, flag}, 16'd0);
        src_alt = 1; step(1);
        check("R11 source switch capture", {15'd0, flag}, 16'd1);
        wr(2'd2, 8'h01);
        check("R11 flag clearable", {15'd0, flag}, 16'd0);

        // wide mode via alternate line
        wide = 1;
        trig_alt = 0; step(5);
        trig_alt = 1; v = cnt;
        step(3);
        check("R4 high byte captured", {8'd0, cmp_hi}, {8'd0, 8'((v + 16'd14) >> 8)});
        check("R4 low byte captured", {8'd0, cmp_lo}, {8'd0, 8'(v + 16'd14)});
        check("R4 compare disabled", {15'd0, cmp_en}, 16'd0);
        wr(2'd2, 8'h01);

        // noise filter
        wide = 0; src_alt = 0; filt_en = 1;
        step(2);
        trig_main = 1; step(3); trig_main = 0;
        step(10);
        check("R12 short pulse rejected", {15'd0, flag}, 16'd0);
        trig_main = 1; v = cnt;
        step(6);
        check("R12 no capture before filter latency", {15'd0, flag}, 16'd0);
        step(1);
        check("R12 filtered capture flag", {15'd0, flag}, 16'd1);
        check("R12 filtered capture value", {8'd0, cmp_lo}, {8'd0, 8'(v + 16'd42)});
        wr(2'd2, 8'h01);
        filt_en = 0;
        step(2);

        // capture and clear in the same cycle
        trig_main = 0; step(5);
        trig_main = 1; step(2);
        addr = 2'd2; wdata = 8'h01; wr_en = 1;
        step(1); wr_en = 0;
        check("R8 capture beats clear", {15'd0, flag}, 16'd1);
        wr(2'd2, 8'h01);

        // capture and low-register write in the same cycle
        trig_main = 0; step(5);
        trig_main = 1; v = cnt; step(2);
        addr = 2'd0; wdata = 8'h3C; wr_en = 1;
        step(1); wr_en = 0;
        check("R14 capture beats write", {8'd0, cmp_lo}, {8'd0, 8'(v + 16'd14)});

        // read port
        wr(2'd1, 8'h5A);
        addr = 2'd1; #1;
        check("R13 read high", {8'd0, rd_data}, 16'h005A);
        addr = 2'd3; #1;
        check("R13 read unused", {8'd0, rd_data}, 16'h0000);
        addr = 2'd2; #1;
        check("R13 read flag", {8'd0, rd_data}, 16'h0001);
        step(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule